// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds a small set of control registers that exist once per hardware unit. Units are arranged as groups of instances, and every copy of a given register answers to one bus address. A separate selector register, at an address of its own, holds a group number, an instance number and a broadcast flag. Together they decide which copies a write reaches and which copy a read returns.

Two masks, each with one bit per unit, mark units that are fused off or power gated. An access aimed at such a unit is terminated. A terminated read returns zero, and a terminated write is dropped without any error. A broadcast write skips every absent unit, so a gated unit keeps its contents and shows them again once the gate is released. The flat unit number is group × instances-per-group + instance. The bus accepts at most one access per cycle and returns read data one cycle after the request.

Top module: `steered_reg_bank`

## Requirements
- R1: After reset the selector reads 0x8000_0000: broadcast flag set, group 0, instance 0. Every copy of every replicated register reads zero.
- R2: The selector sits at address 0 and replicated register k sits at address 1+k. A read of any other address returns zero, and a write to any other address changes no copy and does not change the selector.
- R3: Selector layout: instance in bits [7:0], group in bits [15:8], broadcast flag in bit 31. Only the low bits that the parameters need are kept, and every other bit reads zero.
- R4: With the broadcast flag set, a write to a replicated address stores the data in that register of every present, powered unit.
- R5: With the broadcast flag clear, a write stores the data only in the unit that group and instance select. All other units keep their values.
- R6: A read of a replicated address returns the copy held by the selected unit, whatever the broadcast flag holds.
- R7: A read aimed at a unit whose fuse bit or gate bit is 1 returns zero.
- R8: A unicast write aimed at a fused or gated unit is dropped. That copy holds its old value after the unit becomes present again.
- R9: A broadcast write leaves gated units unchanged. Their old contents read back once the gate bit returns to 0.
- R10: rdValid is high exactly in the cycle after a read request and carries rdData. While rdValid is low, rdData is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Word address |
| busWdata | input | DATA_W | Write data |
| unitFused | input | NUM_GROUPS*INST_PER_GROUP | 1 = unit fused off |
| unitGated | input | NUM_GROUPS*INST_PER_GROUP | 1 = unit power gated |
| rdValid | output | 1 | Read data valid |
| rdData | output | DATA_W | Read data |

## Verification
Every read result is due at the first sampling point after the clock edge that captured the request, so one cycle later. The read task queues its expected word as it drives the request, and a monitor on the falling edge pops the queue whenever rdValid is high. A result that arrives late or early therefore lines up with the wrong entry, or with an empty queue, and is reported. Writes and selector changes take effect at the capturing edge, and the very next access already observes them. The write task checks, one cycle after each write, that rdValid stayed low.

// File: rtl/steer_pkg.sv
package steer_pkg;

  // Selector field positions; software relies on these bit locations.
  localparam int SEL_INST_LSB = 0;
  localparam int SEL_GRP_LSB  = 8;
  localparam int SEL_MC_BIT   = 31;

  // Strobes from the control to the datapath for the current access.
  typedef struct packed {
    logic wrAll;   // broadcast write of a replicated register
    logic wrOne;   // unicast write to the steered, live unit
    logic rdReq;   // any read request this cycle
    logic rdCopy;  // read from the steered, live unit
    logic rdSel;   // read of the selector
  } bankCmd_t;

endpackage

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import steer_pkg::*;
#(
  parameter int NUM_GROUPS     = 2,
  parameter int INST_PER_GROUP = 4,
  parameter int NUM_REGS       = 4,
  parameter int DATA_W         = 32,
  parameter int ADDR_W         = 4,
  parameter int SEL_ADDR       = 0,
  parameter int REG_BASE       = 1
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  busValid,
  input  logic                                  busWrite,
  input  logic [ADDR_W-1:0]                     busAddr,
  input  logic                                  wrMcBit,
  input  logic [((NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1)-1:0]         wrGrpF,
  input  logic [((INST_PER_GROUP > 1) ? $clog2(INST_PER_GROUP) : 1)-1:0] wrInstF,
  input  logic [NUM_GROUPS*INST_PER_GROUP-1:0]  unitFused,
  input  logic [NUM_GROUPS*INST_PER_GROUP-1:0]  unitGated,
  output bankCmd_t                              cmd,
  output logic [((NUM_REGS > 1) ? $clog2(NUM_REGS) : 1)-1:0]             regIdx,
  output logic [((NUM_GROUPS*INST_PER_GROUP > 1) ? $clog2(NUM_GROUPS*INST_PER_GROUP) : 1)-1:0] unitIdx,
  output logic [DATA_W-1:0]                     selWord,
  output logic                                  selMc,
  output logic [((NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1)-1:0]         selGrp,
  output logic [((INST_PER_GROUP > 1) ? $clog2(INST_PER_GROUP) : 1)-1:0] selInst
);

  localparam int NUM_UNITS = NUM_GROUPS * INST_PER_GROUP;
  localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam int INST_W    = (INST_PER_GROUP > 1) ? $clog2(INST_PER_GROUP) : 1;
  localparam int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
  localparam int REG_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [ADDR_W-1:0] regOff;
  logic              replHit;
  logic              selHit;
  logic [31:0]       unitWide;
  logic              inRange;
  logic              targetLive;
  logic              wrReq;
  logic              rdReq;

  // Address decode
  assign regOff  = busAddr - ADDR_W'(REG_BASE);
  assign replHit = (busAddr >= ADDR_W'(REG_BASE)) && (regOff < ADDR_W'(NUM_REGS));
  assign selHit  = (busAddr == ADDR_W'(SEL_ADDR));
  assign regIdx  = regOff[REG_W-1:0];

  // Steering target and its presence
  assign unitWide   = 32'(selGrp) * 32'(INST_PER_GROUP) + 32'(selInst);
  assign inRange    = (unitWide < 32'(NUM_UNITS)) && (32'(selInst) < 32'(INST_PER_GROUP));
  assign unitIdx    = unitWide[UNIT_W-1:0];
  assign targetLive = inRange && !unitFused[unitIdx] && !unitGated[unitIdx];

  assign wrReq = busValid && busWrite;
  assign rdReq = busValid && !busWrite;

  always_comb begin
    cmd        = '0;
    cmd.wrAll  = wrReq && replHit && selMc;
    cmd.wrOne  = wrReq && replHit && !selMc && targetLive;
    cmd.rdReq  = rdReq;
    cmd.rdCopy = rdReq && replHit && targetLive;
    cmd.rdSel  = rdReq && selHit;
  end

  // Selector register
  always_ff @(posedge clk) begin
    if (rst) begin
      selMc   <= 1'b1;
      selGrp  <= '0;
      selInst <= '0;
    end else if (wrReq && selHit) begin
      selMc   <= wrMcBit;
      selGrp  <= wrGrpF;
      selInst <= wrInstF;
    end
  end

  always_comb begin
    selWord                          = '0;
    selWord[SEL_MC_BIT]              = selMc;
    selWord[SEL_GRP_LSB +: GRP_W]    = selGrp;
    selWord[SEL_INST_LSB +: INST_W]  = selInst;
  end

endmodule

// File: rtl/steer_datapath.sv
module steer_datapath
  import steer_pkg::*;
#(
  parameter int NUM_GROUPS     = 2,
  parameter int INST_PER_GROUP = 4,
  parameter int NUM_REGS       = 4,
  parameter int DATA_W         = 32
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  bankCmd_t                              cmd,
  input  logic [((NUM_REGS > 1) ? $clog2(NUM_REGS) : 1)-1:0] regIdx,
  input  logic [((NUM_GROUPS*INST_PER_GROUP > 1) ? $clog2(NUM_GROUPS*INST_PER_GROUP) : 1)-1:0] unitIdx,
  input  logic [DATA_W-1:0]                     wrData,
  input  logic [NUM_GROUPS*INST_PER_GROUP-1:0]  unitFused,
  input  logic [NUM_GROUPS*INST_PER_GROUP-1:0]  unitGated,
  input  logic [DATA_W-1:0]                     selWord,
  output logic                                  rdValid,
  output logic [DATA_W-1:0]                     rdData
);

  localparam int NUM_UNITS = NUM_GROUPS * INST_PER_GROUP;
  localparam int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;

  logic [NUM_UNITS-1:0][DATA_W-1:0] unitPick;

  // One storage row per unit; each row decides its own write enable.
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [DATA_W-1:0] copyQ [NUM_REGS];
    logic              unitLive;
    logic              wrHit;

    assign unitLive = !unitFused[u] && !unitGated[u];
    assign wrHit    = unitLive && (cmd.wrAll || (cmd.wrOne && (unitIdx == UNIT_W'(u))));

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int r = 0; r < NUM_REGS; r++) copyQ[r] <= '0;
      end else if (wrHit) begin
        copyQ[regIdx] <= wrData;
      end
    end

    assign unitPick[u] = copyQ[regIdx];
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= cmd.rdReq;
      if (cmd.rdCopy)     rdData <= unitPick[unitIdx];
      else if (cmd.rdSel) rdData <= selWord;
      else                rdData <= '0;
    end
  end

endmodule

// File: rtl/steered_reg_bank.sv
module steered_reg_bank
  import steer_pkg::*;
#(
  parameter int NUM_GROUPS     = 2,
  parameter int INST_PER_GROUP = 4,
  parameter int NUM_REGS       = 4,
  parameter int DATA_W         = 32,
  parameter int ADDR_W         = 4,
  parameter int SEL_ADDR       = 0,
  parameter int REG_BASE       = 1
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 busValid,
  input  logic                                 busWrite,
  input  logic [ADDR_W-1:0]                    busAddr,
  input  logic [DATA_W-1:0]                    busWdata,
  input  logic [NUM_GROUPS*INST_PER_GROUP-1:0] unitFused,
  input  logic [NUM_GROUPS*INST_PER_GROUP-1:0] unitGated,
  output logic                                 rdValid,
  output logic [DATA_W-1:0]                    rdData
);

  localparam int NUM_UNITS = NUM_GROUPS * INST_PER_GROUP;
  localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam int INST_W    = (INST_PER_GROUP > 1) ? $clog2(INST_PER_GROUP) : 1;
  localparam int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
  localparam int REG_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  bankCmd_t          cmd;
  logic [REG_W-1:0]  regIdx;
  logic [UNIT_W-1:0] unitIdx;
  logic [DATA_W-1:0] selWord;
  logic              selMc;
  logic [GRP_W-1:0]  selGrp;
  logic [INST_W-1:0] selInst;
  logic              wrMcBit;
  logic [GRP_W-1:0]  wrGrpF;
  logic [INST_W-1:0] wrInstF;

  assign wrMcBit = busWdata[SEL_MC_BIT];
  assign wrGrpF  = busWdata[SEL_GRP_LSB +: GRP_W];
  assign wrInstF = busWdata[SEL_INST_LSB +: INST_W];

  steer_ctrl #(
    .NUM_GROUPS(NUM_GROUPS), .INST_PER_GROUP(INST_PER_GROUP), .NUM_REGS(NUM_REGS),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR), .REG_BASE(REG_BASE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .wrMcBit(wrMcBit), .wrGrpF(wrGrpF), .wrInstF(wrInstF),
    .unitFused(unitFused), .unitGated(unitGated),
    .cmd(cmd), .regIdx(regIdx), .unitIdx(unitIdx), .selWord(selWord),
    .selMc(selMc), .selGrp(selGrp), .selInst(selInst)
  );

  steer_datapath #(
    .NUM_GROUPS(NUM_GROUPS), .INST_PER_GROUP(INST_PER_GROUP),
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rst(rst), .cmd(cmd), .regIdx(regIdx), .unitIdx(unitIdx),
    .wrData(busWdata), .unitFused(unitFused), .unitGated(unitGated),
    .selWord(selWord), .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: rtl/steered_reg_bank_chk.sv
module steered_reg_bank_chk #(
  parameter int NUM_GROUPS     = 2,
  parameter int INST_PER_GROUP = 4,
  parameter int NUM_REGS       = 4,
  parameter int DATA_W         = 32,
  parameter int ADDR_W         = 4,
  parameter int SEL_ADDR       = 0,
  parameter int REG_BASE       = 1
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic                                 busValid,
  input logic                                 busWrite,
  input logic [ADDR_W-1:0]                    busAddr,
  input logic                                 wrMcBit,
  input logic [((NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1)-1:0]         wrGrpF,
  input logic [((INST_PER_GROUP > 1) ? $clog2(INST_PER_GROUP) : 1)-1:0] wrInstF,
  input logic [NUM_GROUPS*INST_PER_GROUP-1:0] unitFused,
  input logic [NUM_GROUPS*INST_PER_GROUP-1:0] unitGated,
  input logic                                 selMc,
  input logic [((NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1)-1:0]         selGrp,
  input logic [((INST_PER_GROUP > 1) ? $clog2(INST_PER_GROUP) : 1)-1:0] selInst,
  input logic                                 rdValid,
  input logic [DATA_W-1:0]                    rdData
);

  localparam int NUM_UNITS = NUM_GROUPS * INST_PER_GROUP;

  int   tgtUnit;
  logic tgtAbsent;
  logic replAddr;
  logic readReq;

  assign tgtUnit   = int'(selGrp) * INST_PER_GROUP + int'(selInst);
  assign tgtAbsent = (tgtUnit >= NUM_UNITS) || unitFused[tgtUnit] || unitGated[tgtUnit];
  assign replAddr  = (int'(busAddr) >= REG_BASE) && (int'(busAddr) < REG_BASE + NUM_REGS);
  assign readReq   = busValid && !busWrite;

  p_rd_latency_r10: assert property (@(posedge clk) disable iff (rst)
    readReq |=> rdValid);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !readReq |=> (!rdValid && rdData == '0));

  p_term_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (readReq && replAddr && tgtAbsent) |=> (rdData == '0));

  p_sel_update_r3: assert property (@(posedge clk) disable iff (rst)
    (busValid && busWrite && int'(busAddr) == SEL_ADDR) |=>
      (selMc == $past(wrMcBit) && selGrp == $past(wrGrpF) && selInst == $past(wrInstF)));

  p_sel_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(busValid && busWrite && int'(busAddr) == SEL_ADDR) |=>
      ($stable(selMc) && $stable(selGrp) && $stable(selInst)));

endmodule

bind steered_reg_bank steered_reg_bank_chk #(
  .NUM_GROUPS(NUM_GROUPS), .INST_PER_GROUP(INST_PER_GROUP), .NUM_REGS(NUM_REGS),
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR), .REG_BASE(REG_BASE)
) u_chk (
  .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
  .wrMcBit(wrMcBit), .wrGrpF(wrGrpF), .wrInstF(wrInstF),
  .unitFused(unitFused), .unitGated(unitGated),
  .selMc(selMc), .selGrp(selGrp), .selInst(selInst),
  .rdValid(rdValid), .rdData(rdData)
);

// File: tb/sim_steered_reg_bank.sv
module sim_steered_reg_bank;

  localparam int NG = 2;
  localparam int NI = 4;
  localparam int NR = 4;
  localparam int NU = NG * NI;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          busValid = 1'b0;
  logic          busWrite = 1'b0;
  logic [3:0]    busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [NU-1:0] unitFused = '0;
  logic [NU-1:0] unitGated = '0;
  logic          rdValid;
  logic [31:0]   rdData;

  int checks = 0;
  int fails  = 0;
  bit doneFlag = 1'b0;

  // Reference model, built from the requirements
  logic [31:0] mdl [NU][NR];
  logic        mMc   = 1'b1;
  int          mGrp  = 0;
  int          mInst = 0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  steered_reg_bank u0 (
    .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .unitFused(unitFused), .unitGated(unitGated),
    .rdValid(rdValid), .rdData(rdData)
  );

  function automatic bit liveUnit(int u);
    return !unitFused[u] && !unitGated[u];
  endfunction

  function automatic logic [31:0] expRead(logic [3:0] a);
    int u;
    u = mGrp * NI + mInst;
    if (a == 4'd0) return {mMc, 15'd0, 7'd0, 1'(mGrp), 6'd0, 2'(mInst)};
    if (a >= 4'd1 && a <= 4'(NR)) return liveUnit(u) ? mdl[u][int'(a) - 1] : 32'd0;
    return 32'd0;
  endfunction

  task automatic busWr(logic [3:0] a, logic [31:0] d);
    int u;
    if (a == 4'd0) begin
      mMc = d[31]; mGrp = int'(d[8]); mInst = int'(d[1:0]);
    end else if (a >= 4'd1 && a <= 4'(NR)) begin
      if (mMc) begin
        for (int k = 0; k < NU; k++) if (liveUnit(k)) mdl[k][int'(a) - 1] = d;
      end else begin
        u = mGrp * NI + mInst;
        if (liveUnit(u)) mdl[u][int'(a) - 1] = d;
      end
    end
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; busWdata = '0;
    checks++;
    if (rdValid !== 1'b0 || rdData !== 32'd0) begin
      fails++;
      $display("FAIL R10 after write: rdValid=%0b rdData=%h expected 0/0", rdValid, rdData);
    end
  endtask

  task automatic busRd(logic [3:0] a, string tag);
    expQ.push_back(expRead(a));
    tagQ.push_back(tag);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic selectUnit(bit mc, int g, int i);
    busWr(4'd0, {mc, 15'd0, 8'(g), 8'(i)});
  endtask

  // Monitor: pops one expected word for each valid read result
  always @(negedge clk) begin
    if (!rst && rdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected rdValid: rdData=%h expected no result", rdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (rdData !== e) begin
          fails++;
          $display("FAIL %s: got %h expected %h", t, rdData, e);
        end
      end
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!doneFlag) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      finishRun();
    end
  end

  initial begin
    for (int u = 0; u < NU; u++) for (int r = 0; r < NR; r++) mdl[u][r] = 32'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    busRd(4'd0, "R1 selector reset");
    busRd(4'd1, "R1 copy reset");

    // R4 / R6: broadcast write, then read units back with the flag still set
    busWr(4'd2, 32'h0000_00A5);
    for (int u = 0; u < NU; u += 3) begin
      selectUnit(1'b1, u / NI, u % NI);
      busRd(4'd2, "R4 R6 broadcast readback");
    end

    // R5: unicast to group 1 instance 2 (unit 6)
    selectUnit(1'b0, 1, 2);
    busWr(4'd2, 32'h0000_1234);
    busRd(4'd2, "R5 unicast target");
    selectUnit(1'b0, 1, 1);
    busRd(4'd2, "R5 neighbour untouched");
    selectUnit(1'b0, 0, 0);
    busRd(4'd2, "R5 unit0 untouched");

    // R7: fused unit 3, gated unit 4
    unitFused[3] = 1'b1;
    unitGated[4] = 1'b1;
    selectUnit(1'b1, 0, 3);
    busRd(4'd2, "R7 fused read zero");
    selectUnit(1'b1, 1, 0);
    busRd(4'd2, "R7 gated read zero");

    // R8: unicast write to gated unit 4 is dropped
    selectUnit(1'b0, 1, 0);
    busWr(4'd3, 32'hDEAD_BEEF);
    // R9: broadcast write skips gated and fused units
    selectUnit(1'b1, 0, 0);
    busWr(4'd1, 32'h0000_0077);
    unitGated[4] = 1'b0;
    selectUnit(1'b1, 1, 0);
    busRd(4'd3, "R8 dropped unicast write");
    busRd(4'd1, "R9 gated copy kept");
    busRd(4'd2, "R9 gated copy kept older");
    selectUnit(1'b1, 1, 1);
    busRd(4'd1, "R4 live copy updated");
    unitFused[3] = 1'b0;
    selectUnit(1'b1, 0, 3);
    busRd(4'd1, "R9 fused copy kept");

    // R2: unmapped addresses
    busRd(4'd9, "R2 unmapped read");
    busWr(4'd12, 32'hFFFF_FFFF);
    busRd(4'd0, "R2 selector unchanged");
    busRd(4'd1, "R2 copy unchanged");
    busRd(4'd4, "R2 last register");

    // R3: selector layout with all bits written
    busWr(4'd0, 32'hFFFF_FFFF);
    busRd(4'd0, "R3 selector fields");
    busWr(4'd0, 32'h7FFF_00FE);
    busRd(4'd0, "R3 selector cleared flag");
    busRd(4'd2, "R6 read with flag clear");

    // R10: back-to-back reads
    busRd(4'd1, "R10 back-to-back a");
    busRd(4'd0, "R10 back-to-back b");

    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R10 pending results: got %0d left expected 0", expQ.size());
    end
    doneFlag = 1'b1;
    finishRun();
  end

endmodule